// File: doc/BRIEF.md
# Single-Bank USB Endpoint Handshake Controller

This block is the control and status logic for one endpoint of a full-speed USB device. The endpoint has a single packet buffer and no alternating banks. Firmware sees a status/control word and a byte-wide transmit data port. The protocol engine sees an abstract token interface: it reports each received SETUP, OUT or IN token and each host handshake or timeout. In return it receives the device's answer and, for IN tokens, the stream of packet bytes. Serial coding, CRC and the transceiver sit outside this block.

Ownership of the flags is shared. Firmware fills the buffer and marks it ready. Hardware answers the next IN token with the buffered bytes. When the host acknowledges the packet, hardware frees the buffer and raises a completion flag. A received SETUP or an unconsumed OUT packet makes later OUT packets be refused until firmware clears the flag. Each flag is cleared by writing zero to its bit. A read-modify-write therefore cannot wipe out an event that hardware has just posted.

Top module: `usb_sbep_ctrl`

## Requirements
- R1: After reset, csr_rdata is all zero, irq is 0 and resp_valid is 0.
- R2: A fifo_wr pulse while the ready flag (csr bit 4) is 0 stores the byte and increments the byte count in csr_rdata[11:8]. While the ready flag is 1, fifo_wr is ignored.
- R3: Writing csr_wbits[4]=1 sets the ready flag. The next IN token (tok_pid=3) gets resp_code DATA (2) one cycle later. The buffered bytes follow in write order, one per cycle, with the first byte in the same cycle as the response. An empty buffer gives DATA with no bytes.
- R4: host_ack after a DATA response sets the completion flag (csr bit 0), clears the ready flag and resets the byte count to 0.
- R5: irq is 1 exactly while the completion, setup (bit 1) or receive-data (bit 2) flag is set. Flag bits 0 to 3 are cleared only by a csr write with a 0 in that position. A 1 in that position leaves the flag unchanged.
- R6: A SETUP token (tok_pid=1) is answered with ACK (resp_code 1) and sets the setup flag.
- R7: An OUT token (tok_pid=2) is answered with NAK (resp_code 0) while the setup flag or the receive-data flag is set. Otherwise it is answered with ACK and sets the receive-data flag.
- R8: An IN token while the ready flag is 0 is answered with NAK, and no data bytes are sent.
- R9: host_timeout after a DATA response leaves the ready flag at 1 and the completion flag at 0. The next IN token resends the same bytes.
- R10: A fifo_wr pulse while the buffer holds DEPTH bytes is dropped and sets the sticky overflow flag (bit 3). The byte count never exceeds DEPTH.
- R11: While ep_iso is 1, IN tokens are answered with NAK and host_ack never sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_iso | input | 1 | Endpoint configured as isochronous |
| csr_wr | input | 1 | Status/control write strobe |
| csr_wbits | input | 5 | Bits 0..3 write-zero-to-clear flags; bit 4 writes one to set ready |
| csr_rdata | output | 16 | Flags in bits 4..0, byte count in bits 11:8 |
| fifo_wr | input | 1 | Transmit data write strobe |
| fifo_wdata | input | DATA_W | Transmit data byte |
| tok_valid | input | 1 | Token reported this cycle |
| tok_pid | input | 2 | Token kind: 1 SETUP, 2 OUT, 3 IN |
| host_ack | input | 1 | Host acknowledged the IN data packet |
| host_timeout | input | 1 | Host did not acknowledge the IN data packet |
| resp_valid | output | 1 | Device response valid |
| resp_code | output | 2 | 0 NAK, 1 ACK, 2 DATA |
| tx_valid | output | 1 | IN data byte valid |
| tx_data | output | DATA_W | IN data byte |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. The small depth lets a short run fill the buffer completely, hit the overflow on the fifth write and stream a full-length packet. The same run also covers the zero-length packet, the timeout retry and the isochronous refusal. A scoreboard queues the expected responses and bytes, so ordering and retransmission are compared byte by byte.

// File: rtl/sbep_pkg.sv
package sbep_pkg;
   typedef enum logic [1:0] {
      PID_NONE  = 2'd0,
      PID_SETUP = 2'd1,
      PID_OUT   = 2'd2,
      PID_IN    = 2'd3
   } tok_e;

   typedef enum logic [1:0] {
      RSP_NAK  = 2'd0,
      RSP_ACK  = 2'd1,
      RSP_DATA = 2'd2
   } rsp_e;

   localparam int FLG_TXC   = 0;
   localparam int FLG_SETUP = 1;
   localparam int FLG_RXD   = 2;
   localparam int FLG_OVF   = 3;
   localparam int FLG_TXRDY = 4;
   localparam int CNT_LSB   = 8;
   localparam int CNT_FIELD = 4;
   localparam int CSR_W     = 16;

   typedef struct packed {
      logic txrdy;
      logic ovf;
      logic rxd;
      logic setup;
      logic txc;
   } flags_t;
endpackage

// File: rtl/sbep_txbuf.sv
module sbep_txbuf #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              release_buf,
   input  logic              start,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_pulse,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic              wr_fire;
   logic              active_q;
   logic [CNT_W-1:0]  idx_q;

   assign wr_fire   = wr_en && (count != FULL);
   assign ovf_pulse = wr_en && (count == FULL);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else if (wr_fire && (count == CNT_W'(i))) begin
            slot_q[i] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (release_buf) begin
         count <= '0;
      end else if (wr_fire) begin
         count <= count + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
      end else if (start) begin
         active_q <= (count != '0);
         idx_q    <= '0;
      end else if (active_q) begin
         if (idx_q == count - ONE) begin
            active_q <= 1'b0;
         end
         idx_q <= idx_q + ONE;
      end
   end

   always_comb begin
      tx_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (idx_q == CNT_W'(i)) begin
            tx_data = slot_q[i];
         end
      end
   end

   assign tx_valid = active_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL); // R10
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && count == FULL && !release_buf) |=> (count == FULL)); // R10
   AST_STREAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (idx_q < count)); // R3
endmodule

// File: rtl/sbep_flags.sv
module sbep_flags
   import sbep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fw_wr,
   input  logic [4:0] fw_bits,
   input  logic       set_txc,
   input  logic       set_setup,
   input  logic       set_rxd,
   input  logic       set_ovf,
   input  logic       clr_txrdy,
   output flags_t     flg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flg <= '0;
      end else begin
         if (set_txc)                           flg.txc <= 1'b1;
         else if (fw_wr && !fw_bits[FLG_TXC])   flg.txc <= 1'b0;

         if (set_setup)                         flg.setup <= 1'b1;
         else if (fw_wr && !fw_bits[FLG_SETUP]) flg.setup <= 1'b0;

         if (set_rxd)                           flg.rxd <= 1'b1;
         else if (fw_wr && !fw_bits[FLG_RXD])   flg.rxd <= 1'b0;

         if (set_ovf)                           flg.ovf <= 1'b1;
         else if (fw_wr && !fw_bits[FLG_OVF])   flg.ovf <= 1'b0;

         if (clr_txrdy)                         flg.txrdy <= 1'b0;
         else if (fw_wr && fw_bits[FLG_TXRDY])  flg.txrdy <= 1'b1;
      end
   end

   AST_SETUP_W0C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg.setup) |-> ($past(fw_wr) && !$past(fw_bits[FLG_SETUP]))); // R5
   AST_TXC_W0C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg.txc) |-> ($past(fw_wr) && !$past(fw_bits[FLG_TXC]))); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg.ovf) |-> $past(fw_wr)); // R10
endmodule

// File: rtl/sbep_proto.sv
module sbep_proto
   import sbep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_valid,
   input  logic [1:0] tok_pid,
   input  logic       host_ack,
   input  logic       host_timeout,
   input  logic       ep_iso,
   input  logic       setup_flag,
   input  logic       rxd_flag,
   input  logic       txrdy_flag,
   output logic       start_tx,
   output logic       set_setup,
   output logic       set_rxd,
   output logic       pkt_acked,
   output logic       resp_valid,
   output logic [1:0] resp_code
);
   tok_e tok;
   logic is_setup, is_out, is_in, out_block, in_flight_q;
   rsp_e rsp_d;

   assign tok       = tok_e'(tok_pid);
   assign is_setup  = tok_valid && (tok == PID_SETUP);
   assign is_out    = tok_valid && (tok == PID_OUT);
   assign is_in     = tok_valid && (tok == PID_IN);
   assign out_block = setup_flag || rxd_flag;

   assign set_setup = is_setup;
   assign set_rxd   = is_out && !out_block;
   assign start_tx  = is_in && txrdy_flag && !ep_iso;
   assign pkt_acked = host_ack && in_flight_q && !ep_iso;

   always_comb begin
      rsp_d = RSP_NAK;
      if (is_setup)                rsp_d = RSP_ACK;
      else if (is_out)             rsp_d = out_block ? RSP_NAK : RSP_ACK;
      else if (is_in && start_tx)  rsp_d = RSP_DATA;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_flight_q <= 1'b0;
         resp_valid  <= 1'b0;
         resp_code   <= RSP_NAK;
      end else begin
         if (start_tx)                      in_flight_q <= 1'b1;
         else if (host_ack || host_timeout) in_flight_q <= 1'b0;
         resp_valid <= tok_valid && (tok != PID_NONE);
         resp_code  <= rsp_d;
      end
   end

   AST_OUT_NAK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out && (setup_flag || rxd_flag)) |=> (resp_valid && resp_code == RSP_NAK)); // R7
   AST_IN_NAK_NOTRDY: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in && !txrdy_flag) |=> (resp_valid && resp_code == RSP_NAK)); // R8
   AST_ISO_IN_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in && ep_iso) |=> (resp_valid && resp_code == RSP_NAK)); // R11
   AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      is_setup |=> (resp_valid && resp_code == RSP_ACK)); // R6
endmodule

// File: rtl/usb_sbep_ctrl.sv
module usb_sbep_ctrl
   import sbep_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ep_iso,
   input  logic              csr_wr,
   input  logic [4:0]        csr_wbits,
   output logic [15:0]       csr_rdata,
   input  logic              fifo_wr,
   input  logic [DATA_W-1:0] fifo_wdata,
   input  logic              tok_valid,
   input  logic [1:0]        tok_pid,
   input  logic              host_ack,
   input  logic              host_timeout,
   output logic              resp_valid,
   output logic [1:0]        resp_code,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1 || DEPTH > 15) begin : g_bad_depth
      $error("DEPTH must lie in 1..15 to fit the count field");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   flags_t           flg;
   logic [CNT_W-1:0] count;
   logic             start_tx, set_setup, set_rxd, pkt_acked, ovf_pulse;

   sbep_proto u_proto (
      .clk(clk), .rst_n(rst_n),
      .tok_valid(tok_valid), .tok_pid(tok_pid),
      .host_ack(host_ack), .host_timeout(host_timeout), .ep_iso(ep_iso),
      .setup_flag(flg.setup), .rxd_flag(flg.rxd), .txrdy_flag(flg.txrdy),
      .start_tx(start_tx), .set_setup(set_setup), .set_rxd(set_rxd),
      .pkt_acked(pkt_acked),
      .resp_valid(resp_valid), .resp_code(resp_code)
   );

   sbep_txbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fifo_wr && !flg.txrdy), .wr_data(fifo_wdata),
      .release_buf(pkt_acked), .start(start_tx),
      .count(count), .ovf_pulse(ovf_pulse),
      .tx_valid(tx_valid), .tx_data(tx_data)
   );

   sbep_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .fw_wr(csr_wr), .fw_bits(csr_wbits),
      .set_txc(pkt_acked), .set_setup(set_setup), .set_rxd(set_rxd),
      .set_ovf(ovf_pulse), .clr_txrdy(pkt_acked),
      .flg(flg)
   );

   always_comb begin
      csr_rdata = '0;
      csr_rdata[FLG_TXC]   = flg.txc;
      csr_rdata[FLG_SETUP] = flg.setup;
      csr_rdata[FLG_RXD]   = flg.rxd;
      csr_rdata[FLG_OVF]   = flg.ovf;
      csr_rdata[FLG_TXRDY] = flg.txrdy;
      csr_rdata[CNT_LSB +: CNT_FIELD] = CNT_FIELD'(count);
   end

   assign irq = flg.txc || flg.setup || flg.rxd;

   AST_TXC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg.txc) |-> $past(host_ack)); // R4
   AST_TXRDY_FALL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg.txrdy) |-> ($past(host_ack) && count == '0)); // R4
   AST_ISO_NO_TXC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ep_iso) && ep_iso) |-> !$rose(flg.txc)); // R11
   AST_TIMEOUT_KEEPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      (host_timeout && !host_ack && flg.txrdy && !csr_wr) |=> flg.txrdy); // R9
endmodule

// File: tb/usb_sbep_ctrl_tb.sv
module usb_sbep_ctrl_tb_top;
   localparam int DEPTH  = 4;
   localparam int DATA_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ep_iso = 1'b0;
   logic csr_wr = 1'b0;
   logic [4:0] csr_wbits = '0;
   logic [15:0] csr_rdata;
   logic fifo_wr = 1'b0;
   logic [DATA_W-1:0] fifo_wdata = '0;
   logic tok_valid = 1'b0;
   logic [1:0] tok_pid = '0;
   logic host_ack = 1'b0;
   logic host_timeout = 1'b0;
   logic resp_valid;
   logic [1:0] resp_code;
   logic tx_valid;
   logic [DATA_W-1:0] tx_data;
   logic irq;

   int checks = 0;
   int errors = 0;
   int exp_rsp[$];
   int exp_byte[$];
   int exp_req[$];
   int exp_breq[$];
   logic [DATA_W-1:0] buf_model[$];

   always #2 clk = ~clk;

   usb_sbep_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ep_iso(ep_iso),
      .csr_wr(csr_wr), .csr_wbits(csr_wbits), .csr_rdata(csr_rdata),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .tok_valid(tok_valid), .tok_pid(tok_pid),
      .host_ack(host_ack), .host_timeout(host_timeout),
      .resp_valid(resp_valid), .resp_code(resp_code),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: compares responses and bytes against the scoreboard queues
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         if (exp_rsp.size() == 0) chk("R3 unexpected response", resp_code, 99);
         else begin
            int rq;
            rq = exp_req.pop_front();
            chk($sformatf("R%0d response", rq), resp_code, exp_rsp.pop_front());
         end
      end
      if (rst_n && tx_valid) begin
         if (exp_byte.size() == 0) chk("R8 unexpected byte", tx_data, 999);
         else begin
            int rq;
            rq = exp_breq.pop_front();
            chk($sformatf("R%0d byte", rq), tx_data, exp_byte.pop_front());
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic csr_write(input logic [4:0] v);
      @(negedge clk); csr_wr = 1'b1; csr_wbits = v;
      @(negedge clk); csr_wr = 1'b0; csr_wbits = '0;
   endtask

   task automatic fifo_push(input logic [DATA_W-1:0] d);
      @(negedge clk); fifo_wr = 1'b1; fifo_wdata = d;
      @(negedge clk); fifo_wr = 1'b0;
   endtask

   // driver: sends a token and pushes the expected outcome into the scoreboard
   task automatic token(input logic [1:0] pid, input int rsp, input int req, input bit with_data);
      exp_rsp.push_back(rsp);
      exp_req.push_back(req);
      if (with_data) begin
         foreach (buf_model[i]) begin
            exp_byte.push_back(buf_model[i]);
            exp_breq.push_back(req);
         end
      end
      @(negedge clk); tok_valid = 1'b1; tok_pid = pid;
      @(negedge clk); tok_valid = 1'b0; tok_pid = '0;
      idle(DEPTH + 2);
   endtask

   task automatic pulse_ack();
      @(negedge clk); host_ack = 1'b1;
      @(negedge clk); host_ack = 1'b0;
   endtask

   task automatic pulse_timeout();
      @(negedge clk); host_timeout = 1'b1;
      @(negedge clk); host_timeout = 1'b0;
   endtask

   function automatic int csr_val(input int cnt, input bit rdy, input bit ovf,
                                  input bit rxd, input bit stp, input bit txc);
      return (cnt << 8) | (int'(rdy) << 4) | (int'(ovf) << 3) | (int'(rxd) << 2)
             | (int'(stp) << 1) | int'(txc);
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      idle(3);
      // R1 reset state
      chk("R1 csr", csr_rdata, 0);
      chk("R1 irq", irq, 0);
      chk("R1 resp_valid", resp_valid, 0);
      rst_n = 1'b1;
      idle(2);

      // R8 IN with nothing armed
      token(2'd3, 0, 8, 1'b0);

      // R2 load three bytes
      buf_model = '{8'hA1, 8'hA2, 8'hA3};
      foreach (buf_model[i]) fifo_push(buf_model[i]);
      chk("R2 count", csr_rdata, csr_val(3, 0, 0, 0, 0, 0));
      csr_write(5'h1F);
      chk("R3 ready set", csr_rdata, csr_val(3, 1, 0, 0, 0, 0));
      fifo_push(8'hEE);
      chk("R2 write while ready ignored", csr_rdata, csr_val(3, 1, 0, 0, 0, 0));

      // R3 data, R9 timeout and retry
      token(2'd3, 2, 3, 1'b1);
      pulse_timeout();
      chk("R9 ready kept", csr_rdata, csr_val(3, 1, 0, 0, 0, 0));
      chk("R9 irq low", irq, 0);
      token(2'd3, 2, 9, 1'b1);
      pulse_ack();
      chk("R4 after ack", csr_rdata, csr_val(0, 0, 0, 0, 0, 1));
      chk("R5 irq on completion", irq, 1);

      // R5 write-one leaves flag, write-zero clears
      csr_write(5'h0F);
      chk("R5 write one keeps flag", csr_rdata, csr_val(0, 0, 0, 0, 0, 1));
      csr_write(5'h0E);
      chk("R5 write zero clears", csr_rdata, csr_val(0, 0, 0, 0, 0, 0));
      chk("R5 irq cleared", irq, 0);

      // R3 zero-length packet
      buf_model.delete();
      csr_write(5'h1F);
      token(2'd3, 2, 3, 1'b1);
      pulse_ack();
      chk("R3 zero-length completes", csr_rdata, csr_val(0, 0, 0, 0, 0, 1));
      csr_write(5'h0E);

      // R10 overflow at DEPTH
      buf_model = '{8'h11, 8'h22, 8'h33, 8'h44};
      foreach (buf_model[i]) fifo_push(buf_model[i]);
      fifo_push(8'h55);
      chk("R10 overflow flag", csr_rdata, csr_val(4, 0, 1, 0, 0, 0));
      chk("R10 overflow no irq", irq, 0);
      csr_write(5'h0F);
      chk("R10 overflow sticky", csr_rdata, csr_val(4, 0, 1, 0, 0, 0));
      csr_write(5'h07);
      chk("R10 overflow cleared", csr_rdata, csr_val(4, 0, 0, 0, 0, 0));
      csr_write(5'h1F);
      token(2'd3, 2, 10, 1'b1);
      pulse_ack();
      chk("R4 full packet released", csr_rdata, csr_val(0, 0, 0, 0, 0, 1));
      csr_write(5'h0E);

      // R6 setup, R7 out gating
      token(2'd1, 1, 6, 1'b0);
      chk("R6 setup flag", csr_rdata, csr_val(0, 0, 0, 0, 1, 0));
      chk("R6 irq", irq, 1);
      token(2'd2, 0, 7, 1'b0);
      chk("R7 no rxd while setup", csr_rdata, csr_val(0, 0, 0, 0, 1, 0));
      csr_write(5'h0D);
      token(2'd2, 1, 7, 1'b0);
      chk("R7 rxd set", csr_rdata, csr_val(0, 0, 0, 1, 0, 0));
      chk("R7 irq rxd", irq, 1);
      token(2'd2, 0, 7, 1'b0);
      csr_write(5'h0B);
      chk("R7 rxd cleared", csr_rdata, csr_val(0, 0, 0, 0, 0, 0));

      // R11 isochronous
      ep_iso = 1'b1;
      buf_model = '{8'h5A};
      fifo_push(8'h5A);
      csr_write(5'h1F);
      token(2'd3, 0, 11, 1'b0);
      pulse_ack();
      chk("R11 no completion", csr_rdata, csr_val(1, 1, 0, 0, 0, 0));
      ep_iso = 1'b0;
      idle(2);
      token(2'd3, 2, 11, 1'b1);
      pulse_ack();
      chk("R11 normal after iso off", csr_rdata, csr_val(0, 0, 0, 0, 0, 1));

      idle(4);
      chk("R3 scoreboard drained", exp_rsp.size() + exp_byte.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule